// File: doc/BRIEF.md
# Quarter-Step Sample Strobe Generator

This block turns a fast reference clock into a one-cycle sample strobe for a capture controller. A free-running binary prescaler counts reference cycles, and a rate selector picks one of seven internal rates. Each internal rate is one quarter of the rate above it. With the default 50 MHz reference, the rates run from 50 MS/s down to about 12.2 kS/s. A further rate code selects an external sample clock instead. That clock is brought into the reference domain and reduced to one strobe per rising edge.

A 3-bit rate code picks the source. An active-low run input gates all strobes. While run is deasserted, the prescaler is held at zero. When the code changes, the prescaler restarts, so the first strobe at any newly chosen rate comes one full period after the change. The strobe is registered and is always exactly one reference cycle wide.

Top module: `sample_strobe_gen`

## Requirements
- R1: While rst_ni is low, strobe_o is low.
- R2: With rate code 1 and run_ni low, strobe_o is high on every reference cycle, starting with the first clock edge at which run_ni is sampled low.
- R3: Rate codes 2 to 7 divide the reference by N = 4^(code-1): 4, 16, 64, 256, 1024 and 4096. If run_ni is first sampled low at edge c0+1, strobe_o is high exactly in the cycles following edges c0+m·N, for m ≥ 1. Each strobe is one cycle wide.
- R4: Rate code 0 selects ext_clk_i. Each rising edge of ext_clk_i gives exactly one strobe, three reference edges after the input is first sampled high. Both the high and the low level must be held for at least two reference cycles.
- R5: While run_ni is high, strobe_o stays low and the prescaler is held at zero.
- R6: When rate_sel_i differs from the code in use, strobe_o is low in the following cycle. This holds even when a strobe was due at that edge. The prescaler restarts, so the new rate's first strobe comes N cycles after that edge.
- R7: While an internal rate code (1 to 7) is selected, activity on ext_clk_i has no effect on strobe_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External sample clock, asynchronous to the reference |
| rate_sel_i | input | RATE_W | Rate code: 0 selects the external clock; 1 to 7 select divide by 4^(code-1) |
| run_ni | input | 1 | Run enable, active low; high suppresses every strobe |
| strobe_o | output | 1 | One-cycle sample strobe |

## Verification
Two events can fall on the same edge.

- **Rate change and terminal count.** A rate-code change can land exactly on the edge where the old rate's terminal count would fire. The bench switches from divide-by-4 to divide-by-16 at the negative edge just before such a due strobe. It expects that strobe to be dropped and the first divide-by-16 strobe to come a full 16 cycles after the change.
- **External edges and internal rate.** Edges of the external clock can arrive while an internal rate is active. The bench toggles ext_clk_i every cycle during internal-rate runs and during a halted window. It expects the strobe pattern to match the internal schedule exactly and the halted window to be silent.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int unsigned CODE_EXT = 0;

  // prescaler bits that must all be ones for a given internal rate code
  function automatic int tap_bits(input int code, input int step_w);
    return (code < 1) ? 0 : step_w * (code - 1);
  endfunction
endpackage

// File: rtl/ssg_prescaler.sv
module ssg_prescaler #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else              cnt_o <= cnt_o + 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_o == '0); // R5
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> cnt_o == $past(cnt_o) + 1'b1); // R3
endmodule

// File: rtl/ssg_ext_sync.sv
module ssg_ext_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R4
endmodule

// File: rtl/ssg_rate_mux.sv
module ssg_rate_mux #(
  parameter int unsigned RATE_W = 3,
  parameter int unsigned STEP_W = 2,
  parameter int unsigned CNT_W  = 12
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [RATE_W-1:0] code_i,
  input  logic              ext_edge_i,
  output logic              hit_o
);
  localparam int unsigned NUM_CODES = 2 ** RATE_W;

  logic [NUM_CODES-1:0] hit_vec;

  assign hit_vec[ssg_pkg::CODE_EXT] = ext_edge_i;

  for (genvar k = 1; k < NUM_CODES; k++) begin : g_tap
    localparam int TB = ssg_pkg::tap_bits(k, STEP_W);
    if (TB == 0) begin : g_every
      assign hit_vec[k] = 1'b1;
    end else begin : g_terminal
      assign hit_vec[k] = &cnt_i[TB-1:0];
    end
  end

  assign hit_o = hit_vec[code_i];
endmodule

// File: rtl/sample_strobe_gen.sv
module sample_strobe_gen #(
  parameter int unsigned RATE_W      = 3,
  parameter int unsigned STEP_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              run_ni,
  output logic              strobe_o
);
  localparam int unsigned NUM_CODES = 2 ** RATE_W;
  localparam int unsigned CNT_W     = STEP_W * (NUM_CODES - 2);

  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt;
  logic              code_chg;
  logic              clear;
  logic              ext_edge;
  logic              hit;

  assign code_chg = rate_sel_i != rate_q;
  assign clear    = run_ni | code_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= RATE_W'(1);
      strobe_o <= 1'b0;
    end else begin
      rate_q   <= rate_sel_i;
      strobe_o <= ~clear & hit;
    end
  end

  ssg_prescaler #(.CNT_W(CNT_W)) i_prescaler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .cnt_o   (cnt)
  );

  ssg_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) i_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clk_i),
    .edge_o (ext_edge)
  );

  ssg_rate_mux #(.RATE_W(RATE_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) i_rate_mux (
    .cnt_i      (cnt),
    .code_i     (rate_q),
    .ext_edge_i (ext_edge),
    .hit_o      (hit)
  );

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> !strobe_o); // R1
  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_ni && !code_chg && rate_q == RATE_W'(1)) |=> strobe_o); // R2
  AST_SLOW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && rate_q != RATE_W'(1)) |=> !strobe_o); // R3
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_ni |=> !strobe_o); // R5
  AST_SWITCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_chg |=> !strobe_o); // R6
endmodule

// File: tb/test_sample_strobe_gen.sv
module test_sample_strobe_gen;
  localparam int RATE_W = 3;
  localparam int LIMIT  = 150000;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ext_clk_i = 1'b0;
  logic [RATE_W-1:0] rate_sel_i = RATE_W'(1);
  logic              run_ni = 1'b1;
  logic              strobe_o;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  int   seen = 0;
  bit   noise = 1'b0;
  exp_t q[$];

  sample_strobe_gen #(.RATE_W(RATE_W)) i_sample_strobe_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ext_clk_i),
    .rate_sel_i (rate_sel_i),
    .run_ni     (run_ni),
    .strobe_o   (strobe_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected strobe cycles
  always @(negedge clk_i) begin
    if (rst_ni && strobe_o) begin
      seen++;
      if (q.size() == 0) begin
        chk(1'b0, "R5 R6 R7 unexpected strobe", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, e.tag, cyc, e.cyc);
      end
    end
  end

  always @(negedge clk_i) if (noise) ext_clk_i <= ~ext_clk_i;

  always @(posedge clk_i) if (cyc > LIMIT) begin
    chk(1'b0, "watchdog", cyc, LIMIT);
    finish_run();
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push_sched(input int base, input int code, input int lim, input string tag);
    int n;
    n = 1 << (2 * (code - 1));
    for (int m = 1; base + m * n <= lim; m++) q.push_back('{base + m * n, tag});
  endtask

  task automatic drain(input string tag);
    chk(q.size() == 0, tag, q.size(), 0);
    q.delete();
  endtask

  task automatic setup(input int code);
    run_ni = 1'b1;
    rate_sel_i = RATE_W'(code);
    wait_n(3);
  endtask

  // driver: internal-rate run of nc cycles
  task automatic run_seg(input int code, input int nc, input string tag);
    int c0;
    setup(code);
    c0 = cyc;
    run_ni = 1'b0;
    push_sched(c0, code, c0 + nc, tag);
    wait_n(nc);
    run_ni = 1'b1;
    wait_n(2);
    drain(tag);
  endtask

  task automatic chg_seg(input int a, input int b, input int n1, input int n2, input string tag);
    int c0, c1;
    setup(a);
    c0 = cyc;
    run_ni = 1'b0;
    push_sched(c0, a, c0 + n1, tag);
    wait_n(n1);
    c1 = cyc;
    rate_sel_i = RATE_W'(b);
    push_sched(c1 + 1, b, c1 + n2, tag);
    wait_n(n2);
    run_ni = 1'b1;
    wait_n(2);
    drain(tag);
  endtask

  initial begin
    wait_n(3);
    chk(strobe_o == 1'b0, "R1 strobe in reset", strobe_o, 0);
    rst_ni = 1'b1;
    wait_n(2);
    chk(strobe_o == 1'b0, "R1 strobe after reset", strobe_o, 0);

    run_seg(1, 20, "R2 full rate");
    noise = 1'b1;                         // R7: ext toggling while internal rate runs
    run_seg(2, 40, "R3 R7 div4");
    run_seg(3, 100, "R3 R7 div16");
    noise = 1'b0;
    run_seg(4, 300, "R3 div64");
    run_seg(5, 1100, "R3 div256");
    run_seg(6, 4200, "R3 div1024");
    run_seg(7, 9000, "R3 div4096");

    // R5: halted with noise on ext and full-rate code
    begin
      int s0;
      setup(1);
      noise = 1'b1;
      s0 = seen;
      wait_n(40);
      noise = 1'b0;
      rate_sel_i = RATE_W'(0);
      wait_n(10);
      chk(seen == s0, "R5 strobes while halted", seen - s0, 0);
    end

    chg_seg(2, 3, 11, 40, "R6 change on due strobe");
    chg_seg(1, 4, 10, 200, "R6 fast to slow");
    chg_seg(4, 1, 70, 15, "R6 slow to fast");

    // R4: external clock
    begin
      int t;
      ext_clk_i = 1'b0;
      setup(0);
      run_ni = 1'b0;
      wait_n(3);
      for (int p = 0; p < 6; p++) begin
        t = cyc;
        ext_clk_i = 1'b1;
        q.push_back('{t + 3, "R4 external edge"});
        wait_n(2 + p);
        ext_clk_i = 1'b0;
        wait_n(2 + (p % 3));
      end
      wait_n(5);
      run_ni = 1'b1;
      wait_n(2);
      drain("R4 external edge");
    end

    finish_run();
  end
endmodule